// File: doc/BRIEF.md
# Direct-Mapped Hash Table Cache

This block sits between a join engine's build and probe logic and a slow external hash table. The engine sends reads and writes, each addressed by a hash-table index. The low bits of the index choose one line of a small on-chip store. The remaining upper bits are kept as the line's tag. Each line holds one complete table entry. A read that finds a valid line with a matching tag is answered from the on-chip store. Any other read is sent to the external table, and the answer is passed straight back to the engine.

Whether an entry is kept in the store depends on the join phase, selected by an input:

- **Build phase:** every write is kept in the store.
- **Probe phase:** every read miss is kept in the store when the external table answers.

Writes always go on to the external table too (write-through), so the store never holds the only copy of an entry. Only one miss can be open at a time. The request ready output stays low until that miss is answered. Two counters, one for read hits and one for read misses, let the engine or a bench measure the hit rate.

Top module: `htcache`

## Requirements
- R1: After reset, every line is invalid, both counters read zero, `req_ready` is 1 and `rsp_valid` is 0. This also holds for a reset that comes in the middle of a run: the first read of any index after it is a miss.
- R2: A line is chosen by bits `[LINE_W-1:0]` of the index, and its tag is the remaining upper bits. A fill replaces whatever the chosen line held. Two indices that share the low bits therefore evict each other.
- R3: A read hit raises `rsp_valid` with `rsp_hit`=1 in the cycle after the request is accepted, carries the stored entry, and issues no external request.
- R4: A read miss issues an external read (`mem_req_valid`=1, `mem_req_write`=0, same index) in the cycle the request is accepted. The response comes out with `rsp_hit`=0 in the same cycle as `mem_rsp_valid`, with `rsp_data` equal to `mem_rsp_data`.
- R5: `req_ready` is 0 from the cycle after a miss is accepted up to and including the cycle its external response arrives.
- R6: Every write is passed to the external table in its acceptance cycle (`mem_req_write`=1, same index and data). In build phase (`phase_build`=1) the write is also installed in its line.
- R7: In probe phase (`phase_build`=0), a read miss is installed when its response returns, so the next read of that index hits.
- R8: In build phase, a read miss is not installed, so reading the same index again misses again.
- R9: In probe phase, a write updates the line when its index already hits there, and leaves the line untouched when it does not.
- R10: A write produces no response: `rsp_valid` stays 0 in the cycle after a write is accepted.
- R11: `hit_count` goes up by one for each read hit and `miss_count` by one for each read miss. Writes change neither counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_build | input | 1 | 1 = build phase, 0 = probe phase |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | IDX_W | Hash-table index |
| req_wdata | input | DATA_W | Entry to write |
| rsp_valid | output | 1 | Read response present |
| rsp_hit | output | 1 | Response served from the on-chip store |
| rsp_data | output | DATA_W | Entry read |
| mem_req_valid | output | 1 | External table request |
| mem_req_write | output | 1 | External request is a write |
| mem_req_idx | output | IDX_W | External request index |
| mem_req_wdata | output | DATA_W | External write data |
| mem_rsp_valid | input | 1 | External read data present |
| mem_rsp_data | input | DATA_W | External read data |
| hit_count | output | CNT_W | Read hit counter |
| miss_count | output | CNT_W | Read miss counter |

## Verification
The bench runs a short sequence against an external-table model with a 32-cycle read latency.

- A build-phase write followed by a read of the same index shows that the write was installed.
- A repeated build-phase read miss shows that read misses are not kept in build phase.
- A probe-phase miss followed by a read of the same index shows that probe-phase misses are kept.
- Indices that share line bits but differ in tag show eviction.
- Probe-phase writes, one to a present index and one to an absent index, tell updating apart from allocating.
- Later misses on written indices prove write-through.
- A reset in the middle of the run confirms that every line was made invalid.

// File: rtl/htcache.sv
module htcache #(
  parameter int IDX_W  = 10,
  parameter int LINE_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_build,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [IDX_W-1:0]  mem_req_idx,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int LINES = 1 << LINE_W;
  localparam int TAG_W = IDX_W - LINE_W;

  logic [LINES-1:0]  vld;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  logic              busy, pend_fill, hit_q;
  logic [IDX_W-1:0]  pend_idx;
  logic [DATA_W-1:0] hit_data_q;

  wire [LINE_W-1:0] req_line = req_idx[LINE_W-1:0];
  wire [TAG_W-1:0]  req_tag  = req_idx[IDX_W-1:LINE_W];
  wire [LINE_W-1:0] pend_line = pend_idx[LINE_W-1:0];
  wire [TAG_W-1:0]  pend_tag  = pend_idx[IDX_W-1:LINE_W];

  wire lookup_hit = vld[req_line] && (tag_q[req_line] == req_tag);
  wire fire       = req_valid && req_ready;
  wire rd_hit     = fire && !req_write && lookup_hit;
  wire rd_miss    = fire && !req_write && !lookup_hit;
  wire wr         = fire && req_write;
  wire wr_install = wr && (phase_build || lookup_hit);
  wire ret        = busy && mem_rsp_valid;
  wire ret_fill   = ret && pend_fill;

  assign req_ready     = !busy;
  assign mem_req_valid = wr || rd_miss;
  assign mem_req_write = req_write;
  assign mem_req_idx   = req_idx;
  assign mem_req_wdata = req_wdata;
  assign rsp_valid     = hit_q || ret;
  assign rsp_hit       = hit_q;
  assign rsp_data      = ret ? mem_rsp_data : hit_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pend_fill  <= 1'b0;
      pend_idx   <= '0;
      hit_q      <= 1'b0;
      hit_data_q <= '0;
      vld        <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      hit_q <= rd_hit;
      if (rd_hit) begin
        hit_data_q <= dat_q[req_line];
        hit_count  <= hit_count + 1'b1;
      end
      if (rd_miss) begin
        busy       <= 1'b1;
        pend_fill  <= !phase_build;
        pend_idx   <= req_idx;
        miss_count <= miss_count + 1'b1;
      end else if (ret) begin
        busy <= 1'b0;
      end
      if (wr_install) vld[req_line] <= 1'b1;
      else if (ret_fill) vld[pend_line] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_install) begin
      tag_q[req_line] <= req_tag;
      dat_q[req_line] <= req_wdata;
    end else if (ret_fill) begin
      tag_q[pend_line] <= pend_tag;
      dat_q[pend_line] <= mem_rsp_data;
    end
  end
endmodule

// File: rtl/htcache_chk.sv
module htcache_chk #(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [IDX_W-1:0]  req_idx,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mem_req_valid,
  input logic              mem_req_write,
  input logic [IDX_W-1:0]  mem_req_idx,
  input logic              mem_rsp_valid,
  input logic [DATA_W-1:0] mem_rsp_data,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  wire fire = req_valid && req_ready;

  // R3
  hit_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write && !mem_req_valid) |=> (rsp_valid && rsp_hit));

  // R4
  miss_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && !req_ready) |-> (rsp_valid && !rsp_hit && rsp_data == mem_rsp_data));

  // R5
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |=> !req_ready);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !mem_rsp_valid) |=> !req_ready);

  // R6
  write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write) |-> (mem_req_valid && mem_req_write && mem_req_idx == req_idx));

  // R10
  write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write) |=> !rsp_valid);

  // R11
  hit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (hit_count == CNT_W'($past(hit_count) + 1'b1)));

  // R11
  write_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write) |=> ($stable(hit_count) && $stable(miss_count)));
endmodule

bind htcache htcache_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_idx(req_idx), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_data(rsp_data), .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
  .mem_req_idx(mem_req_idx), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
  .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/htcache_tb.sv
module htcache_tb;
  localparam int IDX_W = 10, LINE_W = 4, DATA_W = 32, CNT_W = 16, LAT = 32;
  localparam int NVEC = 14;
  // {exp_hit, build, write, idx, data}
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 10'h013, 32'h11111111},
    {1'b1, 1'b1, 1'b0, 10'h013, 32'h11111111},
    {1'b0, 1'b1, 1'b0, 10'h024, 32'hC0DE0024},
    {1'b0, 1'b1, 1'b0, 10'h024, 32'hC0DE0024},
    {1'b0, 1'b0, 1'b0, 10'h035, 32'hC0DE0035},
    {1'b1, 1'b0, 1'b0, 10'h035, 32'hC0DE0035},
    {1'b0, 1'b0, 1'b0, 10'h045, 32'hC0DE0045},
    {1'b0, 1'b0, 1'b0, 10'h035, 32'hC0DE0035},
    {1'b0, 1'b0, 1'b1, 10'h035, 32'h22222222},
    {1'b1, 1'b0, 1'b0, 10'h035, 32'h22222222},
    {1'b0, 1'b0, 1'b1, 10'h056, 32'h33333333},
    {1'b0, 1'b0, 1'b0, 10'h056, 32'h33333333},
    {1'b0, 1'b0, 1'b0, 10'h3F3, 32'hC0DE03F3},
    {1'b0, 1'b0, 1'b0, 10'h013, 32'h11111111}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic phase_build = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [IDX_W-1:0] req_idx = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_hit;
  logic [DATA_W-1:0] rsp_data;
  logic mem_req_valid, mem_req_write;
  logic [IDX_W-1:0] mem_req_idx;
  logic [DATA_W-1:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic [CNT_W-1:0] hit_count, miss_count;

  int checks = 0, errors = 0, exp_hits = 0, exp_misses = 0;

  always #2.5 clk = ~clk;

  htcache #(.IDX_W(IDX_W), .LINE_W(LINE_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .phase_build(phase_build), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_idx(req_idx), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write), .mem_req_idx(mem_req_idx),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  logic [DATA_W-1:0] mem [1 << IDX_W];
  logic mpend = 1'b0;
  int mcnt = 0;
  logic [IDX_W-1:0] midx = '0;
  initial for (int i = 0; i < (1 << IDX_W); i++) mem[i] = 32'hC0DE0000 | i;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_write) mem[mem_req_idx] <= mem_req_wdata;
    if (mem_req_valid && !mem_req_write) begin
      mpend <= 1'b1; mcnt <= LAT - 1; midx <= mem_req_idx;
    end else if (mpend) begin
      if (mcnt == 0) begin
        mem_rsp_valid <= 1'b1; mem_rsp_data <= mem[midx]; mpend <= 1'b0;
      end else mcnt <= mcnt - 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string row_req(input int r);
    case (r)
      0, 1: return "R6";
      2, 3: return "R8";
      4, 5: return "R7";
      6, 7, 12, 13: return "R2";
      default: return "R9";
    endcase
  endfunction

  task automatic access(input bit build, input bit wr, input logic [IDX_W-1:0] idx,
                        input logic [DATA_W-1:0] d, input bit exp_hit, input string req);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    phase_build = build; req_valid = 1'b1; req_write = wr; req_idx = idx; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      check(!rsp_valid, "R10", rsp_valid, 0);
      return;
    end
    n = 1;
    while (!rsp_valid && n < 200) begin
      check(!req_ready, "R5", req_ready, 0);
      @(negedge clk); n++;
    end
    if (exp_hit) exp_hits++; else exp_misses++;
    check(rsp_hit == exp_hit, req, rsp_hit, exp_hit);
    check(rsp_data == d, req, rsp_data, d);
    if (exp_hit) check(n == 1, "R3", n, 1);
    else check(n == LAT + 1, "R4", n, LAT + 1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(hit_count == 0 && miss_count == 0, "R1", {hit_count, miss_count}, 0);
    check(req_ready && !rsp_valid, "R1", {req_ready, rsp_valid}, 2'b10);
    for (int r = 0; r < NVEC; r++)
      access(VEC[r][43], VEC[r][42], VEC[r][41:32], VEC[r][31:0], VEC[r][44], row_req(r));
    @(negedge clk);
    check(hit_count == exp_hits, "R11", hit_count, exp_hits);
    check(miss_count == exp_misses, "R11", miss_count, exp_misses);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(hit_count == 0 && miss_count == 0, "R1", {hit_count, miss_count}, 0);
    exp_hits = 0; exp_misses = 0;
    access(1'b0, 1'b0, 10'h035, 32'h22222222, 1'b0, "R1");
    access(1'b0, 1'b0, 10'h035, 32'h22222222, 1'b1, "R7");
    @(negedge clk);
    check(hit_count == 1 && miss_count == 1, "R11", {hit_count, miss_count}, 32'h00010001);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule